// File: doc/BRIEF.md
# Dual-role SPI byte port

This block is an 8-bit full-duplex serial port that runs either as the clock master or as a slave on an SPI bus. A single shifter sends one byte and receives one byte at the same time, most significant bit first. A separate receive holding register keeps the last finished byte. Because of that register, the next byte can start shifting before the host has read the previous one.

The host side is a set of strobes. A write either starts a master transfer or preloads the slave's outgoing byte. A read strobe takes the received byte. Separate clear strobes reset the sticky flags. Static control inputs select:

- the role (master or slave);
- the idle level of SCK;
- which SCK edge launches data;
- where the master samples its input;
- the master bit rate: the system clock divided by 4, 16 or 64, or an external tick;
- whether the slave honours an active-low select line.

In slave mode the pin inputs are brought into the system clock domain by synchronisers. SCK must therefore run at no more than a quarter of the system clock.

Top module: `spi_port`

## Requirements
- R1: Every transfer moves exactly 8 bits in each direction, MSB first. The byte received on `sdi` appears on `rx_data` once the transfer completes. In master mode, with `sdi` looped back to `sdo`, `rx_data` equals the byte written.
- R2: `cpol` sets the idle level of `sck_o` (0 = low, 1 = high). With `cpha`=0, data is sampled on the first (leading) SCK edge of each bit and changes on the trailing edge. With `cpha`=1, data changes on the leading edge and is sampled on the trailing edge.
- R3: In master mode, `smp_end`=0 samples `sdi` at the sample edge of R2. `smp_end`=1 samples it one half SCK period later. Slave mode ignores `smp_end`.
- R4: When a transfer completes, the shifted-in byte is copied to `rx_data`, and `buf_full` and `irq` are set one cycle after `busy` falls. `irq` stays set until `clr_irq`.
- R5: A `host_wr` while `busy` is high is discarded and sets `wcol`. `wcol` stays set until `clr_wcol` is pulsed.
- R6: In master mode a transfer lasts 16 half-periods, or 17 when `smp_end`=1 and `cpha`=1.
  - A half-period is 2, 8 or 32 system clocks for `rate_sel` = 0, 1 and 2.
  - With `rate_sel`=3 it is one `ext_tick` pulse.
  - `busy` is high from the cycle after the write for exactly that many half-periods.
- R7: In slave mode with `ss_enable`=1 and `ss_n` high, the port does not shift, `busy` stays low, no byte completes, and `sdo_oe` is low. In master mode `sdo_oe` equals `en`.
- R8: `host_rd` clears `buf_full`. A byte that completes while `buf_full` is set overwrites `rx_data` and sets `ovf`. `ovf` stays set until `clr_ovf`.
- R9: In master mode, a write accepted while idle with `en`=1 starts the transfer at once. In slave mode the write only preloads the byte, with its MSB shown on `sdo` at once, and the external master's SCK edges move it out.
- R10: Dropping `en` aborts a transfer within one cycle: `busy` clears, `sck_o` returns to the `cpol` level, and the bit position resets. `buf_full`, `wcol`, `ovf` and `irq` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Port enable; low aborts any transfer |
| master_mode | input | 1 | 1 = drive SCK (master), 0 = slave |
| cpol | input | 1 | Idle level of SCK |
| cpha | input | 1 | 0 = sample on leading edge, 1 = launch on leading edge |
| smp_end | input | 1 | Master only: sample half a period late |
| rate_sel | input | 2 | Master rate: 0 /4, 1 /16, 2 /64, 3 external tick |
| ext_tick | input | 1 | Half-period tick when rate_sel = 3 |
| ss_enable | input | 1 | Slave honours ss_n when 1 |
| host_wr | input | 1 | Write strobe for host_wdata |
| host_wdata | input | 8 | Byte to send |
| host_rd | input | 1 | Read strobe; clears buf_full |
| clr_wcol | input | 1 | Clears the collision flag |
| clr_ovf | input | 1 | Clears the overflow flag |
| clr_irq | input | 1 | Clears the interrupt request |
| rx_data | output | 8 | Receive holding register |
| buf_full | output | 1 | Unread byte in rx_data |
| wcol | output | 1 | Sticky write collision |
| ovf | output | 1 | Sticky receive overflow |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Interrupt request, set on completion |
| sck_o | output | 1 | SCK value driven in master mode |
| sck_oe | output | 1 | SCK output enable (master and enabled) |
| sck_i | input | 1 | SCK from the bus in slave mode |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Serial data output enable |
| sdi | input | 1 | Serial data in |
| ss_n | input | 1 | Active-low slave select |

## Verification
The checker watches the flag protocol on every cycle:

- `wcol`, `ovf` and `buf_full` hold until their clear;
- a write during `busy` raises `wcol`;
- `irq` accompanies every rise of `buf_full`;
- `sck_o` sits at the `cpol` level while idle;
- disabling drops `busy`;
- a deselected slave releases `sdo`.

Properties of whole transfers can only be shown by the bench's scenarios. These are byte integrity in each clock mode, the sampling shift that `smp_end` causes, transfer length at each rate, slave preload, and the absence of shifting when deselected. For master runs, a behavioural model in the bench tracks `busy` and all flags cycle by cycle.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

  typedef enum logic [1:0] {
    RATE_SLOW_A = 2'd0,
    RATE_SLOW_B = 2'd1,
    RATE_SLOW_C = 2'd2,
    RATE_EXT    = 2'd3
  } rate_e;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= RST_VAL;
        else     chain[0] <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/spi_rate_gen.sv
module spi_rate_gen
  import spi_port_pkg::*;
#(
  parameter int DIV_A = 4,
  parameter int DIV_B = 16,
  parameter int DIV_C = 64
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  run,
  input  rate_e sel,
  input  logic  ext_tick,
  output logic  tick
);

  localparam int CW = $clog2(DIV_C / 2) + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] half_m1;

  always_comb begin
    case (sel)
      RATE_SLOW_A: half_m1 = CW'(DIV_A / 2 - 1);
      RATE_SLOW_B: half_m1 = CW'(DIV_B / 2 - 1);
      RATE_SLOW_C: half_m1 = CW'(DIV_C / 2 - 1);
      default:     half_m1 = '0;
    endcase
    tick = run && ((sel == RATE_EXT) ? ext_tick : (cnt == half_m1));
  end

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         master,
  input  logic         cpol,
  input  logic         cpha,
  input  logic         smp_end,
  input  logic         ss_enable,
  input  logic         tick_m,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         sdi_raw,
  input  logic         sdi_s,
  input  logic         sck_s,
  input  logic         ss_s,
  output logic         busy,
  output logic         done,
  output logic         run,
  output logic         sck_q,
  output logic         sdo_q,
  output logic [W-1:0] rx_q
);

  localparam int EDGES = 2 * W;
  localparam int TW    = $clog2(EDGES + 1);

  logic [TW-1:0] t;
  logic [TW-1:0] last_t;
  logic          active;
  logic [W-1:0]  tx_sr;
  logic          sck_prev;
  logic          selected, ev, mid_smp, end_smp, smp, launch, in_bit, final_ev;

  always_comb begin
    selected = !ss_enable || !ss_s;
    if (master) ev = en && active && tick_m;
    else        ev = en && selected && (sck_s != sck_prev);
    last_t   = (master && smp_end && cpha) ? TW'(EDGES) : TW'(EDGES - 1);
    mid_smp  = (t < TW'(EDGES)) && (t[0] == cpha);
    end_smp  = (t != '0) && (t[0] == !cpha);
    smp      = (master && smp_end) ? end_smp : mid_smp;
    launch   = (t < TW'(EDGES)) && (t[0] == !cpha);
    in_bit   = master ? sdi_raw : sdi_s;
    final_ev = ev && (t == last_t);
  end

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (rst) begin
      active   <= 1'b0;
      t        <= '0;
      tx_sr    <= '0;
      rx_q     <= '0;
      sdo_q    <= 1'b0;
      sck_q    <= cpol;
      sck_prev <= 1'b0;
    end else begin
      sck_prev <= sck_s;
      if (ev) begin
        if (smp) rx_q <= {rx_q[W-2:0], in_bit};
        if (launch) begin
          sdo_q <= tx_sr[W-1];
          tx_sr <= {tx_sr[W-2:0], 1'b0};
        end
        if (master && (t < TW'(EDGES))) sck_q <= ~sck_q;
        if (final_ev) begin
          t      <= '0;
          active <= 1'b0;
          done   <= 1'b1;
        end else begin
          t <= t + 1'b1;
        end
      end else if (!active) begin
        sck_q <= cpol;
      end
      if (load) begin
        tx_sr <= cpha ? load_data : {load_data[W-2:0], 1'b0};
        sdo_q <= load_data[W-1];
        if (master && en) begin
          active <= 1'b1;
          t      <= '0;
        end
      end
      if (!en) begin
        active <= 1'b0;
        t      <= '0;
        sck_q  <= cpol;
      end else if (!master && !selected) begin
        t <= '0;
      end
    end
  end

  always_comb begin
    busy = master ? active : (t != '0);
    run  = active;
  end

endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_A       = 4,
  parameter int DIV_B       = 16,
  parameter int DIV_C       = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         master_mode,
  input  logic         cpol,
  input  logic         cpha,
  input  logic         smp_end,
  input  logic [1:0]   rate_sel,
  input  logic         ext_tick,
  input  logic         ss_enable,
  input  logic         host_wr,
  input  logic [W-1:0] host_wdata,
  input  logic         host_rd,
  input  logic         clr_wcol,
  input  logic         clr_ovf,
  input  logic         clr_irq,
  output logic [W-1:0] rx_data,
  output logic         buf_full,
  output logic         wcol,
  output logic         ovf,
  output logic         busy,
  output logic         irq,
  output logic         sck_o,
  output logic         sck_oe,
  input  logic         sck_i,
  output logic         sdo,
  output logic         sdo_oe,
  input  logic         sdi,
  input  logic         ss_n
);

  logic [2:0]   pins_s;
  logic         tick_m, run, done, busy_i, load, sck_q, sdo_q;
  logic [W-1:0] rx_shift;
  logic [W-1:0] rx_buf;
  logic         full_q, wcol_q, ovf_q, irq_q, sck_oe_q, sdo_oe_q;

  spi_pin_sync #(
    .W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)
  ) u_sync (
    .clk(clk), .rst(rst), .d({ss_n, sdi, sck_i}), .q(pins_s)
  );

  spi_rate_gen #(
    .DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)
  ) u_rate (
    .clk(clk), .rst(rst), .run(run), .sel(rate_e'(rate_sel)),
    .ext_tick(ext_tick), .tick(tick_m)
  );

  assign load = host_wr && !busy_i;

  spi_shift_engine #(.W(W)) u_eng (
    .clk(clk), .rst(rst), .en(en), .master(master_mode), .cpol(cpol),
    .cpha(cpha), .smp_end(smp_end), .ss_enable(ss_enable), .tick_m(tick_m),
    .load(load), .load_data(host_wdata), .sdi_raw(sdi), .sdi_s(pins_s[1]),
    .sck_s(pins_s[0]), .ss_s(pins_s[2]), .busy(busy_i), .done(done),
    .run(run), .sck_q(sck_q), .sdo_q(sdo_q), .rx_q(rx_shift)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_buf   <= '0;
      full_q   <= 1'b0;
      wcol_q   <= 1'b0;
      ovf_q    <= 1'b0;
      irq_q    <= 1'b0;
      sck_oe_q <= 1'b0;
      sdo_oe_q <= 1'b0;
    end else begin
      if (done) begin
        rx_buf <= rx_shift;
        full_q <= 1'b1;
      end else if (host_rd) begin
        full_q <= 1'b0;
      end
      if (done && full_q && !host_rd) ovf_q <= 1'b1;
      else if (clr_ovf)               ovf_q <= 1'b0;
      if (host_wr && busy_i) wcol_q <= 1'b1;
      else if (clr_wcol)     wcol_q <= 1'b0;
      if (done)         irq_q <= 1'b1;
      else if (clr_irq) irq_q <= 1'b0;
      sck_oe_q <= en && master_mode;
      sdo_oe_q <= en && (master_mode || !ss_enable || !ss_n);
    end
  end

  assign rx_data  = rx_buf;
  assign buf_full = full_q;
  assign wcol     = wcol_q;
  assign ovf      = ovf_q;
  assign irq      = irq_q;
  assign busy     = busy_i;
  assign sck_o    = sck_q;
  assign sck_oe   = sck_oe_q;
  assign sdo      = sdo_q;
  assign sdo_oe   = sdo_oe_q;

endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
  input logic clk,
  input logic rst,
  input logic en,
  input logic master_mode,
  input logic cpol,
  input logic ss_enable,
  input logic ss_n,
  input logic host_wr,
  input logic host_rd,
  input logic clr_wcol,
  input logic clr_ovf,
  input logic busy,
  input logic buf_full,
  input logic wcol,
  input logic ovf,
  input logic irq,
  input logic sck_o,
  input logic sdo_oe
);

  assert_wcol_on_busy_write_R5: assert property (@(posedge clk) disable iff (rst)
    (host_wr && busy) |=> wcol);

  assert_wcol_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (wcol && !clr_wcol && !(host_wr && busy)) |=> wcol);

  assert_full_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (buf_full && !host_rd) |=> buf_full);

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (ovf && !clr_ovf) |=> ovf);

  assert_irq_with_full_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(buf_full) |-> irq);

  assert_sck_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && master_mode && !busy && !$past(busy) && $stable(cpol))
      |-> (sck_o == cpol));

  assert_abort_R10: assert property (@(posedge clk) disable iff (rst)
    !en |=> !busy);

  assert_release_sdo_R7: assert property (@(posedge clk) disable iff (rst)
    (!master_mode && ss_enable && ss_n) |=> !sdo_oe);

endmodule

bind spi_port spi_port_chk u_chk (
  .clk(clk), .rst(rst), .en(en), .master_mode(master_mode), .cpol(cpol),
  .ss_enable(ss_enable), .ss_n(ss_n), .host_wr(host_wr), .host_rd(host_rd),
  .clr_wcol(clr_wcol), .clr_ovf(clr_ovf), .busy(busy), .buf_full(buf_full),
  .wcol(wcol), .ovf(ovf), .irq(irq), .sck_o(sck_o), .sdo_oe(sdo_oe)
);

// File: tb/sim_spi_port.sv
module sim_spi_port;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1, en = 1'b0, master_mode = 1'b0, cpol = 1'b0;
  logic cpha = 1'b0, smp_end = 1'b0, ext_tick = 1'b0, ss_enable = 1'b0;
  logic host_wr = 1'b0, host_rd = 1'b0, clr_wcol = 1'b0, clr_ovf = 1'b0, clr_irq = 1'b0;
  logic [1:0] rate_sel = 2'd0;
  logic [7:0] host_wdata = 8'h00;
  logic sck_i = 1'b0, ss_n = 1'b1, sdi_drv = 1'b0;
  logic [1:0] sdi_mode = 2'd0;
  logic [7:0] rx_data;
  logic buf_full, wcol, ovf, busy, irq, sck_o, sck_oe, sdo, sdo_oe, sdi;

  int vecs = 0, errs = 0;
  bit finished = 1'b0;
  bit model_on = 1'b0;

  assign sdi = (sdi_mode == 2'd0) ? sdo : (sdi_mode == 2'd1) ? sck_o : sdi_drv;

  always #(CLK_PERIOD / 2) clk = ~clk;

  spi_port u0 (
    .clk(clk), .rst(rst), .en(en), .master_mode(master_mode), .cpol(cpol),
    .cpha(cpha), .smp_end(smp_end), .rate_sel(rate_sel), .ext_tick(ext_tick),
    .ss_enable(ss_enable), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd(host_rd), .clr_wcol(clr_wcol), .clr_ovf(clr_ovf), .clr_irq(clr_irq),
    .rx_data(rx_data), .buf_full(buf_full), .wcol(wcol), .ovf(ovf), .busy(busy),
    .irq(irq), .sck_o(sck_o), .sck_oe(sck_oe), .sck_i(sck_i), .sdo(sdo),
    .sdo_oe(sdo_oe), .sdi(sdi), .ss_n(ss_n)
  );

  // behavioural model of master-mode busy and flags
  bit m_busy, m_pend, m_full, m_wcol, m_ovf, m_irq;
  int m_rem;

  function automatic int xfer_cycles();
    int half, edges;
    half  = (rate_sel == 2'd0) ? 2 : (rate_sel == 2'd1) ? 8 : 32;
    edges = (smp_end && cpha) ? 17 : 16;
    return half * edges;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_pend = 0; m_full = 0; m_wcol = 0; m_ovf = 0; m_irq = 0; m_rem = 0;
    end else begin
      bit p;
      p = m_pend;
      if (p) begin
        if (m_full && !host_rd) m_ovf = 1;
        m_full = 1;
        m_irq  = 1;
      end else begin
        if (host_rd) m_full = 0;
        if (clr_ovf) m_ovf = 0;
        if (clr_irq) m_irq = 0;
      end
      if (p && clr_ovf && !(m_full && !host_rd)) m_ovf = m_ovf;
      if (host_wr && m_busy) m_wcol = 1;
      else if (clr_wcol)     m_wcol = 0;
      m_pend = 0;
      if (!en) begin
        m_busy = 0; m_rem = 0;
      end else if (m_busy) begin
        m_rem--;
        if (m_rem == 0) begin m_busy = 0; m_pend = 1; end
      end else if (host_wr && master_mode) begin
        m_busy = 1; m_rem = xfer_cycles();
      end
    end
  end

  always @(negedge clk) begin
    if (model_on && !rst) begin
      vecs++;
      if ({busy, buf_full, wcol, ovf, irq} !== {m_busy, m_full, m_wcol, m_ovf, m_irq}) begin
        errs++;
        $display("FAIL R4 R5 R6 R8 flags busy/full/wcol/ovf/irq actual=%b expected=%b",
                 {busy, buf_full, wcol, ovf, irq}, {m_busy, m_full, m_wcol, m_ovf, m_irq});
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; cyc(3); rst = 1'b0; cyc(1);
  endtask

  task automatic wr(input logic [7:0] d);
    host_wr = 1'b1; host_wdata = d; cyc(1); host_wr = 1'b0;
  endtask

  task automatic rd();
    host_rd = 1'b1; cyc(1); host_rd = 1'b0;
  endtask

  task automatic wait_idle();
    cyc(1);
    while (busy) cyc(1);
    cyc(2);
  endtask

  task automatic slave_xfer(input logic [7:0] out, output logic [7:0] cap);
    cap = 8'h00;
    for (int i = 0; i < 8; i++) begin
      if (!cpha) sdi_drv = out[7-i];
      cyc(8);
      if (!cpha) cap[7-i] = sdo;
      sck_i = ~cpol;
      if (cpha) sdi_drv = out[7-i];
      cyc(8);
      if (cpha) cap[7-i] = sdo;
      sck_i = cpol;
    end
    cyc(8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    logic [7:0] cap;
    do_reset();
    // reset state
    check("reset state", {rx_data, buf_full, wcol, ovf, irq, busy, sdo_oe, sck_oe},
          {8'h00, 7'b0});

    // master mode 0, fastest rate, loopback
    en = 1; master_mode = 1; cpol = 0; cpha = 0; smp_end = 0; rate_sel = 0; sdi_mode = 0;
    model_on = 1;
    cyc(2);
    check("R2 idle sck low", sck_o, 1'b0);
    check("R7 master sdo_oe", sdo_oe, 1'b1);
    wr(8'hA5);
    check("R9 master write starts", busy, 1'b1);
    cyc(3);
    wr(8'h11);
    check("R5 collision flagged", wcol, 1'b1);
    wait_idle();
    check("R1 loopback byte", rx_data, 8'hA5);
    check("R4 buf_full set", buf_full, 1'b1);
    check("R4 irq set", irq, 1'b1);
    clr_wcol = 1; cyc(1); clr_wcol = 0;
    check("R5 wcol cleared", wcol, 1'b0);
    clr_irq = 1; cyc(1); clr_irq = 0;
    wr(8'h3C);
    wait_idle();
    check("R8 overflow", ovf, 1'b1);
    check("R8 overwrite", rx_data, 8'h3C);
    rd();
    check("R8 read clears full", buf_full, 1'b0);
    clr_ovf = 1; cyc(1); clr_ovf = 0;

    // mode 3, /16, late sample
    cpol = 1; cpha = 1; smp_end = 1; rate_sel = 1;
    cyc(2);
    check("R2 idle sck high", sck_o, 1'b1);
    wr(8'h96);
    wait_idle();
    check("R3 late-sample loopback", rx_data, 8'h96);
    rd();

    // mode 1, /64
    cpol = 0; cpha = 1; smp_end = 0; rate_sel = 2;
    cyc(2);
    wr(8'hE7);
    wait_idle();
    check("R6 slow rate byte", rx_data, 8'hE7);
    rd();

    // sample point: sdi follows sck_o
    cpha = 0; rate_sel = 0; sdi_mode = 1;
    cyc(2);
    wr(8'h00);
    wait_idle();
    check("R3 mid sample sees low", rx_data, 8'h00);
    rd();
    smp_end = 1;
    wr(8'h00);
    wait_idle();
    check("R3 end sample sees high", rx_data, 8'hFF);

    // abort (buf_full left set)
    smp_end = 0; sdi_mode = 0; rate_sel = 2;
    wr(8'h5A);
    cyc(40);
    check("R10 running before abort", busy, 1'b1);
    en = 0; cyc(1); en = 1;
    check("R10 busy cleared", busy, 1'b0);
    check("R10 sck idle", sck_o, 1'b0);
    check("R10 flags kept", buf_full, 1'b1);
    rd();

    // external tick
    model_on = 0;
    rate_sel = 3;
    cyc(2);
    wr(8'hC6);
    for (int k = 0; k < 15; k++) begin
      ext_tick = 1; cyc(1); ext_tick = 0; cyc(1);
    end
    check("R6 ext tick still busy", busy, 1'b1);
    ext_tick = 1; cyc(1); ext_tick = 0;
    check("R6 ext tick done", busy, 1'b0);
    cyc(2);
    check("R6 ext tick byte", rx_data, 8'hC6);

    // slave mode 0
    do_reset();
    en = 0; master_mode = 0; cpol = 0; cpha = 0; sck_i = 0; ss_enable = 0; sdi_mode = 2;
    rate_sel = 0; smp_end = 1;
    cyc(4); en = 1; cyc(3);
    wr(8'hC3);
    check("R9 slave preload idle", busy, 1'b0);
    check("R9 slave preload msb", sdo, 1'b1);
    slave_xfer(8'h5A, cap);
    check("R1 slave rx", rx_data, 8'h5A);
    check("R1 slave tx", cap, 8'hC3);
    check("R4 slave full", buf_full, 1'b1);
    rd();

    // slave mode 3 with select
    en = 0; cpol = 1; cpha = 1; sck_i = 1; ss_enable = 1; ss_n = 0;
    cyc(4); en = 1; cyc(3);
    wr(8'h7E);
    slave_xfer(8'h81, cap);
    check("R2 slave mode3 rx", rx_data, 8'h81);
    check("R2 slave mode3 tx", cap, 8'h7E);
    check("R7 selected drives sdo", sdo_oe, 1'b1);
    rd();

    // deselected
    ss_n = 1; cyc(3);
    check("R7 sdo released", sdo_oe, 1'b0);
    slave_xfer(8'hFF, cap);
    check("R7 no byte when deselected", buf_full, 1'b0);
    check("R7 no busy when deselected", busy, 1'b0);
    check("R7 rx unchanged", rx_data, 8'h81);

    // slave collision mid-transfer
    ss_n = 0; cyc(3);
    sck_i = 0; cyc(6);
    wr(8'hAA);
    check("R5 slave collision", wcol, 1'b1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule